// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the winding current of one full bridge in a stepper motor driver. While the bridge is driving, a current-sense comparator reports when the current has reached its trip level. The controller then takes the bridge out of drive for a fixed off-time, counted in clock cycles, and afterwards drives again. Every time the controller changes the bridge outputs, it ignores the comparator for a programmable blanking window. Switching transients would otherwise cause false trips.

How the current decays during the off-time depends on the most recent step event. If the last step commanded a lower current than the step before it, the selected decay mode applies:

- Slow: slow decay for the whole off-time.
- Fast: fast decay for the whole off-time.
- Mixed: fast decay for a programmable part of the off-time, then slow decay for the remainder.

In every other case the off-time uses slow decay. An active-low enable and a fault input force the bridge into an all-off state. Step events are still recorded while the bridge is forced off. Reset stands for undervoltage lockout: it disables the bridge and raises a home indication toward the step translator.

Top module: `fixed_off_chopper`

## Requirements
- R1: Suppose the bridge has been driving past its blanking window and `trip_i` is high at a clock edge. The bridge then leaves drive from the next cycle for exactly `off_len_i` cycles (a value of 0 counts as 1). After that it returns to drive.
- R2: Each time the bridge enters drive, `blank_len_i` is captured at that edge. For that many drive cycles, `trip_i` has no effect.
- R3: Each `step_evt_i` pulse records `step_down_i` as the "falling" flag. An off period uses the flag value held when its trip is accepted. A step event on that same edge affects only later off periods.
- R4: In mixed mode with the falling flag set, the off period shows fast decay for `fast_len_i` cycles and then slow decay until it ends.
- R5: While `en_n_i` is high, the bridge output is all-off from the next cycle, and any off period in progress is abandoned. Step events are still recorded during this time. The cycle after release shows all-off, and then drive begins with a fresh blanking window.
- R6: While `fault_i` is high, the bridge is all-off from the next cycle. It resumes exactly as in R5 once the fault clears.
- R7: During reset and right after it:
  - The bridge is all-off.
  - `home_o` is 1.
  - The falling flag is cleared.

  `home_o` drops to 0 the cycle after the first step event.
- R8: When the falling flag is clear, the whole off period uses slow decay, whatever the mode select.
- R9: In mixed mode, a fast-decay length greater than the off length is clamped to the off length. The off period therefore still ends after `off_len_i` cycles.
- R10: The mode select is encoded as 00 = slow, 01 = mixed, 10 = fast, 11 = slow. `bridge_o` is encoded as 00 = all-off, 01 = drive, 10 = fast decay, 11 = slow decay.
- R11: `off_len_i`, `fast_len_i` and the mode select are captured at the edge that accepts a trip. Changing them during an off period does not affect that period.
- R12: In fast mode with the falling flag set, the whole off period uses fast decay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (undervoltage lockout) |
| trip_i | input | 1 | Current-sense comparator trip |
| step_evt_i | input | 1 | One-cycle pulse per translator step |
| step_down_i | input | 1 | With `step_evt_i`: new step targets lower current |
| decay_sel_i | input | 2 | Decay mode select (R10 encoding) |
| off_len_i | input | DUR_W | Fixed off-time in cycles |
| blank_len_i | input | DUR_W | Blanking window in cycles |
| fast_len_i | input | DUR_W | Fast-decay portion of a mixed off-time in cycles |
| en_n_i | input | 1 | Active-low output enable |
| fault_i | input | 1 | Over-temperature or low gate supply fault |
| bridge_o | output | 2 | Bridge state (R10 encoding) |
| home_o | output | 1 | Home indication toward the translator |

## Verification
Every state is registered, so a wrong internal count shows on `bridge_o` within one cycle of the edge where it matters:

- A corrupted off counter moves the return to drive earlier or later.
- A wrong fast counter shifts the fast-to-slow changeover in a mixed off period.
- A stale blanking count lets a trip through, or holds one back, on the first drive cycles after a switch.
- A wrong falling flag only becomes visible at the next accepted trip, as the wrong decay code in the first off cycle.

The bench compares the bridge code and the home flag against a cycle model on every clock, so these errors are found in the cycle where they first appear.

// File: rtl/chopper_pkg.sv
// Shared encodings for the fixed off-time chopper.
// Assumes a 2-bit bridge code and a 2-bit decay-mode select.
package chopper_pkg;

    // Bridge output states (R10 encoding)
    typedef enum logic [1:0] {
        BR_OFF   = 2'b00,
        BR_DRIVE = 2'b01,
        BR_FAST  = 2'b10,
        BR_SLOW  = 2'b11
    } bridge_t;

    // Decay-mode select codes (R10 encoding); 11 behaves as slow
    typedef enum logic [1:0] {
        DK_SLOW  = 2'b00,
        DK_MIXED = 2'b01,
        DK_FASTM = 2'b10,
        DK_RSVD  = 2'b11
    } decay_t;

endpackage

// File: rtl/chop_decay_plan.sv
// Decides, at the edge that accepts a trip, how long the off period runs
// and how many of its cycles use fast decay.
// Assumes durations are unsigned cycle counts; an off length of zero is
// treated as one cycle. Purely combinational.
module chop_decay_plan #(
    parameter int DUR_W = 12
) (
    input  logic             falling_i,
    input  logic [1:0]       sel_i,
    input  logic [DUR_W-1:0] off_len_i,
    input  logic [DUR_W-1:0] fast_len_i,
    output logic [DUR_W-1:0] span_o,
    output logic [DUR_W-1:0] fast_o
);
    import chopper_pkg::*;

    localparam logic [DUR_W-1:0] ONE = {{(DUR_W-1){1'b0}}, 1'b1};

    // Off length with a floor of one cycle
    always_comb begin
        span_o = (off_len_i == '0) ? ONE : off_len_i;
    end

    // Fast-decay cycle count from mode, falling flag and clamp
    always_comb begin
        fast_o = '0;
        if (falling_i) begin
            case (sel_i)
                DK_MIXED: fast_o = (fast_len_i > span_o) ? span_o : fast_len_i;
                DK_FASTM: fast_o = span_o;
                default:  fast_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/chop_blank_timer.sv
// Blanking window counter: loaded whenever the bridge enters drive,
// counts down during drive, and reports busy while trips are masked.
// Assumes load and clear are never needed in the same cycle as a tick
// to mean anything other than their priority order (clear, load, tick).
module chop_blank_timer #(
    parameter int DUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [DUR_W-1:0] len_i,
    input  logic             tick_i,
    output logic             busy_o
);
    logic [DUR_W-1:0] left_q;

    // Remaining masked drive cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (clear_i) begin
            left_q <= '0;
        end else if (load_i) begin
            left_q <= len_i;
        end else if (tick_i && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Trips are masked while cycles remain
    always_comb begin
        busy_o = (left_q != '0);
    end

endmodule

// File: rtl/chop_off_timer.sv
// One-shot off-time timer with a nested fast-decay counter.
// Both counts are captured on start and hold "cycles left after this one".
// Assumes span_i >= 1 and fast_i <= span_i.
module chop_off_timer #(
    parameter int DUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic [DUR_W-1:0] span_i,
    input  logic [DUR_W-1:0] fast_i,
    input  logic             adv_i,
    output logic             last_o,
    output logic             fast_last_o
);
    logic [DUR_W-1:0] off_left_q;
    logic [DUR_W-1:0] fast_left_q;

    // Off-period countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_left_q <= '0;
        end else if (clear_i) begin
            off_left_q <= '0;
        end else if (start_i) begin
            off_left_q <= span_i - 1'b1;
        end else if (adv_i && off_left_q != '0) begin
            off_left_q <= off_left_q - 1'b1;
        end
    end

    // Fast-decay portion countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_left_q <= '0;
        end else if (clear_i) begin
            fast_left_q <= '0;
        end else if (start_i) begin
            fast_left_q <= (fast_i == '0) ? '0 : fast_i - 1'b1;
        end else if (adv_i && fast_left_q != '0) begin
            fast_left_q <= fast_left_q - 1'b1;
        end
    end

    // Final-cycle indications
    always_comb begin
        last_o      = (off_left_q == '0);
        fast_last_o = (fast_left_q == '0);
    end

endmodule

// File: rtl/fixed_off_chopper.sv
// Fixed off-time PWM current chopper for one full bridge.
// Registers the bridge state; a trip accepted at an edge changes bridge_o
// one cycle later. Reset models undervoltage lockout. Assumes trip_i is
// already synchronous to clk.
module fixed_off_chopper #(
    parameter int DUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_i,
    input  logic             step_evt_i,
    input  logic             step_down_i,
    input  logic [1:0]       decay_sel_i,
    input  logic [DUR_W-1:0] off_len_i,
    input  logic [DUR_W-1:0] blank_len_i,
    input  logic [DUR_W-1:0] fast_len_i,
    input  logic             en_n_i,
    input  logic             fault_i,
    output logic [1:0]       bridge_o,
    output logic             home_o
);
    import chopper_pkg::*;

    bridge_t          st_q;
    logic             falling_q;
    logic             home_q;
    logic             hold;
    logic             in_off;
    logic             blank_busy;
    logic             chop_start;
    logic             off_last;
    logic             fast_last;
    logic             blank_load;
    logic [DUR_W-1:0] plan_span;
    logic [DUR_W-1:0] plan_fast;

    // Forced-off request and phase decode
    always_comb begin
        hold       = en_n_i | fault_i;
        in_off     = (st_q == BR_FAST) || (st_q == BR_SLOW);
        chop_start = !hold && (st_q == BR_DRIVE) && !blank_busy && trip_i;
        blank_load = !hold && ((st_q == BR_OFF) || (in_off && off_last));
    end

    chop_decay_plan #(.DUR_W(DUR_W)) u_plan (
        .falling_i  (falling_q),
        .sel_i      (decay_sel_i),
        .off_len_i  (off_len_i),
        .fast_len_i (fast_len_i),
        .span_o     (plan_span),
        .fast_o     (plan_fast)
    );

    chop_blank_timer #(.DUR_W(DUR_W)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (hold),
        .load_i  (blank_load),
        .len_i   (blank_len_i),
        .tick_i  (st_q == BR_DRIVE),
        .busy_o  (blank_busy)
    );

    chop_off_timer #(.DUR_W(DUR_W)) u_off (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (hold),
        .start_i     (chop_start),
        .span_i      (plan_span),
        .fast_i      (plan_fast),
        .adv_i       (in_off),
        .last_o      (off_last),
        .fast_last_o (fast_last)
    );

    // Bridge state sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BR_OFF;
        end else if (hold) begin
            st_q <= BR_OFF;
        end else begin
            case (st_q)
                BR_OFF:   st_q <= BR_DRIVE;
                BR_DRIVE: if (chop_start) st_q <= (plan_fast != '0) ? BR_FAST : BR_SLOW;
                BR_FAST: begin
                    if (off_last)       st_q <= BR_DRIVE;
                    else if (fast_last) st_q <= BR_SLOW;
                end
                BR_SLOW:  if (off_last) st_q <= BR_DRIVE;
                default:  st_q <= BR_OFF;
            endcase
        end
    end

    // Falling-current flag and home indication from step events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            falling_q <= 1'b0;
            home_q    <= 1'b1;
        end else if (step_evt_i) begin
            falling_q <= step_down_i;
            home_q    <= 1'b0;
        end
    end

    // Output mapping
    always_comb begin
        bridge_o = st_q;
        home_o   = home_q;
    end

endmodule

// File: rtl/fixed_off_chopper_chk.sv
// Property checker for the fixed off-time chopper, attached by bind.
// Observes ports plus the falling flag register.
module fixed_off_chopper_chk #(
    parameter int DUR_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trip_i,
    input logic             step_evt_i,
    input logic [1:0]       decay_sel_i,
    input logic [DUR_W-1:0] blank_len_i,
    input logic             en_n_i,
    input logic             fault_i,
    input logic [1:0]       bridge_o,
    input logic             home_o,
    input logic             falling_q
);
    import chopper_pkg::*;

    logic off_now;
    logic off_prev;
    logic prev_valid;

    always_comb off_now = (bridge_o == BR_FAST) || (bridge_o == BR_SLOW);

    // Tracks the previous cycle's off phase for entry detection
    always_ff @(posedge clk) begin
        off_prev   <= off_now;
        prev_valid <= rst_n;
    end

    // R1
    off_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && off_now && !off_prev) |-> ($past(bridge_o) == BR_DRIVE && $past(trip_i)));

    // R2
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && bridge_o == BR_DRIVE && $past(bridge_o) != BR_DRIVE &&
         $past(blank_len_i) != '0 && !en_n_i && !fault_i) |=> (bridge_o == BR_DRIVE));

    // R5
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n_i || fault_i) |=> (bridge_o == BR_OFF));

    // R7
    home_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && $past(step_evt_i)) |-> !home_o);

    // R8
    rise_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && off_now && !off_prev && !$past(falling_q)) |-> (bridge_o == BR_SLOW));

    // R4
    no_refast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && $past(bridge_o) == BR_SLOW) |-> (bridge_o != BR_FAST));

    // R10
    rsvd_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_valid && off_now && !off_prev && $past(decay_sel_i) == 2'b11) |-> (bridge_o == BR_SLOW));

endmodule

bind fixed_off_chopper fixed_off_chopper_chk #(.DUR_W(DUR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_i      (trip_i),
    .step_evt_i  (step_evt_i),
    .decay_sel_i (decay_sel_i),
    .blank_len_i (blank_len_i),
    .en_n_i      (en_n_i),
    .fault_i     (fault_i),
    .bridge_o    (bridge_o),
    .home_o      (home_o),
    .falling_q   (falling_q)
);

// File: tb/test_fixed_off_chopper.sv
`timescale 1ns/1ps
module test_fixed_off_chopper;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trip = 1'b0;
    logic         step_evt = 1'b0;
    logic         step_down = 1'b0;
    logic [1:0]   sel = 2'b00;
    logic [W-1:0] off_len = 12'd6;
    logic [W-1:0] blank_len = 12'd3;
    logic [W-1:0] fast_len = 12'd2;
    logic         en_n = 1'b0;
    logic         fault = 1'b0;
    logic [1:0]   bridge;
    logic         home;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R7";

    // Reference state: 0 off, 1 drive, 2 fast, 3 slow
    int m_st = 0, m_off_left = 0, m_fast_left = 0, m_blank = 0;
    bit m_fall = 1'b0, m_home = 1'b1;

    always #2.5 clk = ~clk;

    fixed_off_chopper #(.DUR_W(W)) i_fixed_off_chopper (
        .clk(clk), .rst_n(rst_n), .trip_i(trip), .step_evt_i(step_evt),
        .step_down_i(step_down), .decay_sel_i(sel), .off_len_i(off_len),
        .blank_len_i(blank_len), .fast_len_i(fast_len), .en_n_i(en_n),
        .fault_i(fault), .bridge_o(bridge), .home_o(home)
    );

    task automatic model_edge();
        int span, nfast;
        if (!rst_n) begin
            m_st = 0; m_off_left = 0; m_fast_left = 0; m_blank = 0;
            m_fall = 0; m_home = 1;
            return;
        end
        if (en_n || fault) begin
            m_st = 0; m_off_left = 0; m_fast_left = 0; m_blank = 0;
        end else if (m_st == 0) begin
            m_st = 1; m_blank = int'(blank_len);
        end else if (m_st == 1) begin
            if (m_blank > 0) m_blank--;
            else if (trip) begin
                span = (off_len == 0) ? 1 : int'(off_len);
                nfast = 0;
                if (m_fall && sel == 2'b01) nfast = (int'(fast_len) > span) ? span : int'(fast_len);
                if (m_fall && sel == 2'b10) nfast = span;
                m_off_left = span; m_fast_left = nfast;
                m_st = (nfast > 0) ? 2 : 3;
            end
        end else begin
            m_off_left--;
            if (m_fast_left > 0) m_fast_left--;
            if (m_off_left == 0) begin
                m_st = 1; m_blank = int'(blank_len);
            end else begin
                m_st = (m_fast_left > 0) ? 2 : 3;
            end
        end
        if (step_evt) begin
            m_fall = step_down; m_home = 0;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        vectors++;
        if (int'(bridge) != m_st || home != m_home) begin
            fails++;
            $display("FAIL %s: bridge=%0d home=%0b expected bridge=%0d home=%0b at %0t",
                     cur_req, bridge, home, m_st, m_home, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step_pulse(input bit down);
        step_evt = 1'b1; step_down = down;
        tick();
        step_evt = 1'b0;
    endtask

    initial begin
        // R7: reset state
        cyc(3);
        check(bridge == 2'b00, "R7", bridge, 0);
        check(home == 1'b1, "R7", home, 1);
        rst_n = 1'b1;
        cyc(2);
        check(bridge == 2'b01, "R7", bridge, 1);

        // R1: continuous trip gives periodic slow off periods
        cur_req = "R1";
        trip = 1'b1; cyc(30);
        off_len = 0; cyc(12); off_len = 6;

        // R2: single-cycle trips during blanking are ignored
        cur_req = "R2";
        blank_len = 4;
        for (int i = 0; i < 30; i++) begin trip = i[0]; tick(); end
        trip = 1'b0; cyc(3);

        // R7: home clears after first step; R8 rising step with fast select stays slow
        cur_req = "R7";
        check(home == 1'b1, "R7", home, 1);
        step_pulse(1'b0);
        check(home == 1'b0, "R7", home, 0);
        cur_req = "R8";
        sel = 2'b10; trip = 1'b1; cyc(20);

        // R4: mixed decay on falling step
        cur_req = "R4";
        trip = 1'b0; step_pulse(1'b1);
        sel = 2'b01; fast_len = 2; off_len = 7; trip = 1'b1; cyc(25);

        // R9: fast length clamp
        cur_req = "R9";
        fast_len = 20; off_len = 4; cyc(15);

        // R12: fast mode
        cur_req = "R12";
        sel = 2'b10; off_len = 5; cyc(15);

        // R10: reserved code acts as slow
        cur_req = "R10";
        sel = 2'b11; cyc(15);

        // R11: durations changed mid-period do not affect it
        cur_req = "R11";
        sel = 2'b01; off_len = 8; fast_len = 3; blank_len = 2;
        cyc(6); off_len = 2; fast_len = 1; sel = 2'b00; cyc(20);

        // R3: step on the same edge as a trip affects only later periods
        cur_req = "R3";
        trip = 1'b0; sel = 2'b10; off_len = 4; step_pulse(1'b0); cyc(4);
        trip = 1'b1; step_evt = 1'b1; step_down = 1'b1;
        for (int i = 0; i < 16; i++) tick();
        step_evt = 1'b0;

        // R5: enable abandons off period; steps recorded while disabled
        cur_req = "R5";
        cyc(3); en_n = 1'b1; cyc(2);
        check(bridge == 2'b00, "R5", bridge, 0);
        step_pulse(1'b0); cyc(2); en_n = 1'b0; cyc(15);
        en_n = 1'b1; step_pulse(1'b1); en_n = 1'b0; cyc(15);

        // R6: fault forces all-off until it clears
        cur_req = "R6";
        fault = 1'b1; cyc(4);
        check(bridge == 2'b00, "R6", bridge, 0);
        fault = 1'b0; cyc(15);

        // R7: mid-run reset returns to home
        cur_req = "R7";
        rst_n = 1'b0; cyc(2);
        check(home == 1'b1, "R7", home, 1);
        rst_n = 1'b1; cyc(4);

        // Randomised mix of all inputs (R1 R2 R4 R5 R6)
        cur_req = "random R1";
        for (int i = 0; i < 3000; i++) begin
            trip      = ($urandom_range(0, 1) == 1);
            step_evt  = ($urandom_range(0, 9) == 0);
            step_down = ($urandom_range(0, 1) == 1);
            sel       = 2'($urandom_range(0, 3));
            en_n      = ($urandom_range(0, 39) == 0);
            fault     = ($urandom_range(0, 59) == 0);
            rst_n     = ($urandom_range(0, 499) != 0);
            if ($urandom_range(0, 19) == 0) begin
                off_len   = W'($urandom_range(0, 9));
                blank_len = W'($urandom_range(0, 5));
                fast_len  = W'($urandom_range(0, 9));
            end
            tick();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule